// File: doc/BRIEF.md
# Receive Cell Error Drop Filter

This block sits on one receive link between the upstream cell checkers and the input port controller. Cells arrive one word per cycle, framed by start-of-cell and end-of-cell markers. Two upstream checkers report a parity (BIP) error and a sequence error for each cell. Their flags are only meaningful on the end-of-cell word. The filter holds each cell in an internal store until its last word has arrived. It then decides whether to release the cell downstream or to throw it away.

Each error class has its own inhibit input. Setting an inhibit stops that class from discarding cells and from raising the drop indication. A link-level receive-disable input, sampled on the start-of-cell word, makes the filter ignore a whole cell. An ignored cell is never stored and never produces a drop indication. Accepted cells leave the block in arrival order, one word per cycle, with their markers intact. The output has no backpressure.

Top module: `rx_cell_filter`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `out_valid` and `cell_drop` are 0.
- R2: A cell with no uninhibited error is delivered with all of its words, in order, with `out_sop` on the first word and `out_eop` on the last word.
- R3: If `bip_err` is 1 on the end-of-cell word and `bip_inhibit` is 0, no word of the cell appears at the output.
- R4: If `seq_err` is 1 on the end-of-cell word and `seq_inhibit` is 0, no word of the cell appears at the output.
- R5: An error whose own inhibit bit is 1 neither removes the cell nor raises `cell_drop`.
- R6: A cell that carries both errors, with only one of the two classes inhibited, is still discarded.
- R7: `cell_drop` is high for exactly one cycle, in the cycle after a discarded cell's end-of-cell word is presented, and is low at all other times.
- R8: `rx_disable`=1 on a start-of-cell word makes the filter ignore that entire cell: nothing is output and no `cell_drop` pulse occurs, whatever errors the cell carries.
- R9: A change of `rx_disable` after the start-of-cell word does not affect the cell in progress. The change takes effect only at the next start-of-cell word.
- R10: Error flags and inhibit bits are sampled only on the end-of-cell word. Their values on earlier words have no effect.
- R11: Words with `in_valid`=1 that arrive outside a cell (no preceding start-of-cell word) are ignored.
- R12: Back-to-back cells of up to `MAX_WORDS` words each are handled without loss. A discarded cell does not disturb the cells on either side of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input cell word |
| in_sop | input | 1 | First word of a cell |
| in_eop | input | 1 | Last word of a cell |
| bip_err | input | 1 | Cell parity error, valid with in_eop |
| seq_err | input | 1 | Cell sequence error, valid with in_eop |
| rx_disable | input | 1 | 1 = ignore the cell starting now |
| bip_inhibit | input | 1 | 1 = parity errors do not discard |
| seq_inhibit | input | 1 | 1 = sequence errors do not discard |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Output cell word |
| out_sop | output | 1 | First word of an accepted cell |
| out_eop | output | 1 | Last word of an accepted cell |
| cell_drop | output | 1 | One-cycle pulse per discarded cell |

## Verification
The assertions assume well-formed framing at the input:
- A start-of-cell word never arrives while a cell is still open.
- No cell is longer than `MAX_WORDS`.
- Words arrive no faster than one per cycle.

Under those assumptions the internal store cannot overrun, and an assertion on its occupancy guards that. The stimulus respects these limits: every cell in the vector table and the directed tests is between 1 and 8 words long, and each cell's end-of-cell word is sent before the next start-of-cell word. Stray words sent outside a cell carry no start-of-cell marker, so they exercise the ignore path without breaking the framing assumptions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Outcome of a cell, reported on its end-of-cell word
  typedef enum logic [1:0] {
    VD_NONE = 2'd0,
    VD_KEEP = 2'd1,
    VD_DROP = 2'd2
  } verdict_e;
endpackage

// File: rtl/rxf_gate.sv
// Tracks cell framing and decides per cell whether words are taken.
module rxf_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sop,
  input  logic in_eop,
  input  logic rx_disable,
  output logic wr_en,
  output logic cell_end
);
  logic in_cell_q, in_cell_d;
  logic take_q, take_d;
  logic state_en;
  logic sop_seen;

  assign sop_seen = in_valid & in_sop;
  assign state_en = in_valid & (in_sop | in_cell_q);

  always_comb begin
    wr_en     = 1'b0;
    in_cell_d = in_cell_q;
    take_d    = take_q;
    if (sop_seen) begin
      wr_en     = ~rx_disable;
      take_d    = ~rx_disable;
      in_cell_d = ~in_eop;
    end else if (in_valid && in_cell_q) begin
      wr_en     = take_q;
      in_cell_d = ~in_eop;
    end
  end

  assign cell_end = wr_en & in_eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell_q <= 1'b0;
      take_q    <= 1'b0;
    end else if (state_en) begin
      in_cell_q <= in_cell_d;
      take_q    <= take_d;
    end
  end

  // A cell opened while disabled takes none of its later words
  assert_skip_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_seen && rx_disable && !in_eop) |=> !(wr_en && !in_sop));

  // A cell opened while enabled keeps taking words even if disable rises
  assert_hold_choice_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_seen && !rx_disable && !in_eop) ##1 (in_valid && !in_sop) |-> wr_en);
endmodule

// File: rtl/rxf_judge.sv
// Combines error flags and inhibits on the end-of-cell word.
module rxf_judge
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cell_end,
  input  logic     bip_err,
  input  logic     seq_err,
  input  logic     bip_inhibit,
  input  logic     seq_inhibit,
  output verdict_e verdict,
  output logic     cell_drop
);
  logic drop_now;
  logic drop_d, drop_q;

  assign drop_now = (bip_err & ~bip_inhibit) | (seq_err & ~seq_inhibit);

  always_comb begin
    verdict = VD_NONE;
    if (cell_end) verdict = drop_now ? VD_DROP : VD_KEEP;
  end

  assign drop_d = cell_end & drop_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= drop_d;
  end

  assign cell_drop = drop_q;

  // A drop pulse never lasts two cycles unless two cells ended back to back
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_drop && $past(cell_drop)) |-> $past(cell_end, 2));
endmodule

// File: rtl/rxf_store.sv
// Cell store with a committed boundary: a cell becomes readable only after
// its end-of-cell word is kept; a dropped cell is rewound away.
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  verdict_e          verdict,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int DEPTH = 2 * MAX_WORDS;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int EW    = DATA_W + 2;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] MAXW_P  = PW'(MAX_WORDS);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] cm_ptr_q, cm_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic          rd_go;
  logic          ov_d, ov_q;
  logic [EW-1:0] rd_word;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cm_ptr_d = cm_ptr_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + 1'b1;
    unique case (verdict)
      VD_KEEP: cm_ptr_d = wr_ptr_q + 1'b1;
      VD_DROP: wr_ptr_d = cm_ptr_q;
      default: ;
    endcase
  end

  assign rd_go    = (rd_ptr_q != cm_ptr_q);
  assign rd_ptr_d = rd_ptr_q + PW'(rd_go);
  assign ov_d     = rd_go;
  assign rd_word  = mem[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q[AW-1:0]] <= {wr_sop, wr_eop, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cm_ptr_q <= '0;
      rd_ptr_q <= '0;
      ov_q     <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      cm_ptr_q <= cm_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      ov_q     <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_sop  <= 1'b0;
      out_eop  <= 1'b0;
    end else if (rd_go) begin
      out_data <= rd_word[DATA_W-1:0];
      out_eop  <= rd_word[DATA_W];
      out_sop  <= rd_word[DATA_W+1];
    end
  end

  assign out_valid = ov_q;

  // Checker state: is an output cell open
  logic open_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (out_valid) open_q <= ~out_eop;
  end

  assert_out_framing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sop == !open_q));

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_q - rd_ptr_q) < DEPTH_P);

  assert_cell_fits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_q - cm_ptr_q) <= MAXW_P);

  assert_verdict_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict != VD_NONE) |-> (wr_en && wr_eop));
endmodule

// File: rtl/rx_cell_filter.sv
module rx_cell_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              bip_err,
  input  logic              seq_err,
  input  logic              rx_disable,
  input  logic              bip_inhibit,
  input  logic              seq_inhibit,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              cell_drop
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic     wr_en;
  logic     cell_end;
  verdict_e verdict;

  rxf_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .rx_disable (rx_disable),
    .wr_en      (wr_en),
    .cell_end   (cell_end)
  );

  rxf_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cell_end    (cell_end),
    .bip_err     (bip_err),
    .seq_err     (seq_err),
    .bip_inhibit (bip_inhibit),
    .seq_inhibit (seq_inhibit),
    .verdict     (verdict),
    .cell_drop   (cell_drop)
  );

  rxf_store #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .wr_data   (in_data),
    .wr_sop    (in_sop),
    .wr_eop    (in_eop),
    .verdict   (verdict),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
  );

  assert_drop_after_eop_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    cell_drop |-> $past(in_valid && in_eop));

  assert_drop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    cell_drop |-> $past((bip_err && !bip_inhibit) || (seq_err && !seq_inhibit)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_int |=> !out_valid && !cell_drop);
endmodule

// File: tb/rx_cell_filter_test.sv
`timescale 1ns/1ps
module rx_cell_filter_test;
  localparam int DW = 16;
  localparam int MW = 8;
  localparam int NV = 14;
  localparam int EXPN = 512;

  // Row layout: [11:8] length, [7] bip, [6] seq, [5] bip_inh, [4] seq_inh,
  // [3] disable at sop, [2] toggle disable after sop, [1] expect output, [0] expect drop
  localparam logic [11:0] VEC [NV] = '{
    12'b0100_0000_0010,  // R2 clean 4-word cell
    12'b0001_0000_0010,  // R2 single-word cell
    12'b0101_1000_0001,  // R3 parity error dropped
    12'b0011_0100_0001,  // R4 sequence error dropped
    12'b0100_1010_0010,  // R5 parity error inhibited
    12'b0010_0101_0010,  // R5 sequence error inhibited
    12'b0110_1110_0001,  // R6 both errors, parity inhibited
    12'b0011_1101_0001,  // R6 both errors, sequence inhibited
    12'b1000_1111_0010,  // R5 both inhibited, max length
    12'b0100_1000_1000,  // R8 disabled cell with error
    12'b0011_0000_1100,  // R9 disabled at sop, enabled mid-cell
    12'b0101_0000_0110,  // R9 enabled at sop, disabled mid-cell
    12'b0001_1000_0001,  // R7 single-word drop
    12'b1000_0000_0010   // R12 max length after drop
  };

  function automatic string row_tag(input int r);
    case (r)
      0, 1:        return "R2";
      2:           return "R3";
      3:           return "R4";
      4, 5, 8:     return "R5";
      6, 7:        return "R6";
      9:           return "R8";
      10, 11:      return "R9";
      12:          return "R7";
      default:     return "R12";
    endcase
  endfunction

  logic          clk;
  logic          rst_n;
  logic          in_valid, in_sop, in_eop;
  logic [DW-1:0] in_data;
  logic          bip_err, seq_err, rx_disable, bip_inhibit, seq_inhibit;
  logic          out_valid, out_sop, out_eop, cell_drop;
  logic [DW-1:0] out_data;

  rx_cell_filter #(.DATA_W(DW), .MAX_WORDS(MW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .bip_err(bip_err), .seq_err(seq_err),
    .rx_disable(rx_disable), .bip_inhibit(bip_inhibit), .seq_inhibit(seq_inhibit),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .cell_drop(cell_drop)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW+1:0] exp_word [EXPN];
  string         exp_tag  [EXPN];
  int            exp_cnt = 0;
  int            got_cnt = 0;
  logic          drop_exp [64];
  string         drop_tag [64];
  bit            mon_on = 1'b0;
  bit            done = 1'b0;

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: output stream and drop pulse, sampled on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (cell_drop || drop_exp[cyc % 64]) begin
        checks++;
        if (cell_drop !== drop_exp[cyc % 64]) begin
          fails++;
          $display("FAIL %s/R7 cell_drop at cycle %0d: got %b expected %b",
                   drop_tag[cyc % 64], cyc, cell_drop, drop_exp[cyc % 64]);
        end
      end
      drop_exp[cyc % 64] = 1'b0;
      drop_tag[cyc % 64] = "R7";
      if (out_valid) begin
        checks++;
        if (got_cnt >= exp_cnt) begin
          fails++;
          $display("FAIL R3/R4/R8/R11 unexpected word: got %h expected none",
                   {out_sop, out_eop, out_data});
        end else if ({out_sop, out_eop, out_data} !== exp_word[got_cnt]) begin
          fails++;
          $display("FAIL %s word %0d: got %h expected %h", exp_tag[got_cnt],
                   got_cnt, {out_sop, out_eop, out_data}, exp_word[got_cnt]);
        end
        got_cnt++;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
      bip_err = 1'b0; seq_err = 1'b0; bip_inhibit = 1'b0; seq_inhibit = 1'b0;
      rx_disable = 1'b0;
    end
  endtask

  // Error flags are forced to 1 with inhibits 0 on every non-final word (R10)
  task automatic send_cell(input logic [11:0] v, input logic [DW-1:0] base,
                           input string tag);
    int len;
    len = int'(v[11:8]);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_data    = base + DW'(i);
      in_sop     = (i == 0);
      in_eop     = (i == len - 1);
      rx_disable = (i == 0) ? v[3] : (v[3] ^ v[2]);
      if (i == len - 1) begin
        bip_err = v[7]; seq_err = v[6]; bip_inhibit = v[5]; seq_inhibit = v[4];
        drop_exp[(cyc + 1) % 64] = v[0];
        drop_tag[(cyc + 1) % 64] = tag;
      end else begin
        bip_err = 1'b1; seq_err = 1'b1; bip_inhibit = 1'b0; seq_inhibit = 1'b0;
      end
      if (v[1]) begin
        exp_word[exp_cnt] = {in_sop, in_eop, in_data};
        exp_tag[exp_cnt]  = tag;
        exp_cnt++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin drop_exp[i] = 1'b0; drop_tag[i] = "R7"; end
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    bip_err = 1'b0; seq_err = 1'b0; bip_inhibit = 1'b0; seq_inhibit = 1'b0;
    rx_disable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 during reset
    if (out_valid !== 1'b0 || cell_drop !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: got %b%b expected 00", out_valid, cell_drop);
    end
    rst_n = 1'b1;
    idle(4);
    checks++;  // R1 after release
    if (out_valid !== 1'b0 || cell_drop !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: got %b%b expected 00", out_valid, cell_drop);
    end
    mon_on = 1'b1;

    // Table walk, cells back to back (R12)
    for (int r = 0; r < NV; r++)
      send_cell(VEC[r], DW'(16'h1000 + r * 16), row_tag(r));
    idle(40);

    // R11: stray words with no start marker, carrying an error on the last
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0; in_data = 16'hBAD0;
    @(negedge clk);
    in_data = 16'hBAD1;
    @(negedge clk);
    in_data = 16'hBAD2; in_eop = 1'b1; bip_err = 1'b1;
    idle(1);
    send_cell(12'b0011_0000_0010, 16'h2000, "R11");
    idle(1);
    // R10: errors on every word but the last, then a clean cell right after a drop
    send_cell(12'b0110_0000_0010, 16'h3000, "R10");
    send_cell(12'b0010_0100_0001, 16'h3100, "R4");
    send_cell(12'b0010_0000_0010, 16'h3200, "R12");
    idle(40);

    checks++;  // R12: every accepted word arrived, nothing extra
    if (got_cnt != exp_cnt) begin
      fails++;
      $display("FAIL R12 word count: got %0d expected %0d", got_cnt, exp_cnt);
    end

    // R1: reset asserted mid-run clears outputs at once
    send_cell(12'b0100_0000_0000, 16'h4000, "R1");
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0 || cell_drop !== 1'b0) begin
      fails++;
      $display("FAIL R1 async reset: got %b%b expected 00", out_valid, cell_drop);
    end
    idle(2);
    done = 1'b1;
    finish_run();
  end
endmodule